// File: doc/BRIEF.md
# Sequential Next-Block Prefetch Engine

This block works beside a second-level cache. When the cache reports a read miss on block address `n`, the engine sends out the demand read for `n`. It then walks the following `DEGREE` block addresses, `n+1` up to `n+DEGREE`, one address per cycle. Each probe address goes at the same moment to the cache tag array and to the outstanding-request buffer. The next address in the walk is formed while the current probe is in progress.

Each candidate gets a hit indication from the tags and from the buffer. A candidate becomes a prefetch request only when both indications are low. The prefetches therefore trail the demand read one at a time and overlap with it.

The memory side answers each prefetch with one of two replies. A data reply carries the block, and the engine turns it into an install strobe. A refusal reply only retires the request. A count of unanswered prefetches is kept.

A new miss that arrives during a walk cancels the walk and starts a fresh one.

Top module: `seq_prefetch_engine`

## Requirements
- R1: A miss sampled at a rising edge drives `dmd_valid` high for exactly the next cycle, with `dmd_addr` equal to the miss address.
- R2: After a miss on `n`, the probe port presents `n+j` in the j-th cycle after the miss edge, for j = 1..DEGREE. `lookup_valid` is high in exactly those cycles.
- R3: Candidate addresses wrap modulo 2^ADDR_W. A miss on 16'hFFFE probes FFFF, 0000, 0001 and 0002.
- R4: `tag_hit` and `pend_hit` answer the probe of the previous cycle. The candidate probed in cycle j is issued on `pf_valid`/`pf_addr` in cycle j+2 if and only if both answers are low.
- R5: No prefetch is issued in the first two cycles after a miss edge, so the demand read always comes first.
- R6: A miss during a walk aborts it. Responses still in flight from the old walk are dropped, and the new walk follows R2 and R4 from the new miss edge.
- R7: `busy` is high from the first probe cycle through the cycle that carries the last response, that is cycles 1..DEGREE+1 after the miss edge, and low otherwise.
- R8: With DEGREE = 0 no probe, no prefetch and no `busy` ever appear, but the demand read of R1 is still issued.
- R9: `pf_inflight` rises by one in the cycle after each issued prefetch and falls by one in the cycle after each accepted reply. It saturates at MAX_INFL.
- R10: A reply with `rpl_is_data` = 1 (data) drives `install_valid` in the next cycle with `install_addr` equal to `rpl_addr`. A reply with `rpl_is_data` = 0 (refused) installs nothing. Both kinds count down `pf_inflight`.
- R11: A reply that arrives while `pf_inflight` is 0 is ignored: no install is made and the count stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Second-level read miss strobe |
| miss_addr | input | ADDR_W | Block address of the miss |
| dmd_valid | output | 1 | Demand read request |
| dmd_addr | output | ADDR_W | Demand read block address |
| lookup_valid | output | 1 | Probe to tags and request buffer |
| lookup_addr | output | ADDR_W | Probed candidate address |
| tag_hit | input | 1 | Previous probe hit in the tags |
| pend_hit | input | 1 | Previous probe already pending in buffer |
| pf_valid | output | 1 | Prefetch request |
| pf_addr | output | ADDR_W | Prefetch block address |
| rpl_valid | input | 1 | Prefetch reply strobe |
| rpl_is_data | input | 1 | 1 = data reply, 0 = refusal |
| rpl_addr | input | ADDR_W | Block address of the reply |
| install_valid | output | 1 | Install a prefetched block |
| install_addr | output | ADDR_W | Address of block to install |
| pf_inflight | output | $clog2(MAX_INFL+1) | Unanswered prefetch count |
| busy | output | 1 | Walk or response still in progress |

## Verification
Every result is due at a fixed offset from the miss edge:
- The demand read is due one cycle after the edge.
- Probe j is due j cycles after the edge.
- The prefetch decision for probe j is due two cycles after that probe.
- The count and install updates are due one cycle after their cause.

The bench drives inputs on falling edges and walks a cycle index from the miss edge, so each output is compared on the falling edge of exactly the cycle it is due. It checks the idle value in every other cycle of the window, which also catches early or repeated outputs. A responder in the bench answers each probe one cycle late from masks of cached and pending addresses. From those same masks the bench works out on its own which candidates must be issued.

// File: rtl/spf_pkg.sv
package spf_pkg;
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_e;

    typedef enum logic {
        RPL_REFUSED = 1'b0,
        RPL_DATA    = 1'b1
    } rpl_kind_e;
endpackage

// File: rtl/spf_walker.sv
module spf_walker
    import spf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEGREE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              probe_valid,
    output logic [ADDR_W-1:0] probe_addr
);
    localparam int LEFT_W = (DEGREE > 1) ? $clog2(DEGREE) : 1;

    generate
        if (DEGREE == 0) begin : g_off
            assign probe_valid = 1'b0;
            assign probe_addr  = '0;
        end else begin : g_on
            localparam logic [ADDR_W-1:0] ADDR_ONE  = ADDR_W'(1);
            localparam logic [LEFT_W-1:0] LEFT_ONE  = LEFT_W'(1);
            localparam logic [LEFT_W-1:0] LEFT_INIT = LEFT_W'(DEGREE - 1);

            typedef struct packed {
                walk_state_e       st;
                logic [ADDR_W-1:0] addr;
                logic [LEFT_W-1:0] left;
            } walk_t;

            walk_t walk_d, walk_q;

            always_comb begin
                walk_d = walk_q;
                if (miss_valid) begin
                    walk_d.st   = WALK_RUN;
                    walk_d.addr = miss_addr + ADDR_ONE;
                    walk_d.left = LEFT_INIT;
                end else if (walk_q.st == WALK_RUN) begin
                    if (walk_q.left == '0) begin
                        walk_d.st = WALK_IDLE;
                    end else begin
                        walk_d.addr = walk_q.addr + ADDR_ONE;
                        walk_d.left = walk_q.left - LEFT_ONE;
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    walk_q <= '{st: WALK_IDLE, addr: '0, left: '0};
                end else begin
                    walk_q <= walk_d;
                end
            end

            assign probe_valid = (walk_q.st == WALK_RUN);
            assign probe_addr  = walk_q.addr;

            assert_walk_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
                miss_valid |=> (probe_valid && probe_addr == $past(miss_addr) + ADDR_ONE));

            assert_walk_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (probe_valid && walk_q.left != '0 && !miss_valid)
                |=> (probe_valid && probe_addr == $past(probe_addr) + ADDR_ONE));
        end
    endgenerate
endmodule

// File: rtl/spf_issue.sv
module spf_issue #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              probe_valid,
    input  logic [ADDR_W-1:0] probe_addr,
    input  logic              tag_hit,
    input  logic              pend_hit,
    output logic              dmd_valid,
    output logic [ADDR_W-1:0] dmd_addr,
    output logic              rsp_busy,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);
    typedef struct packed {
        logic              dmd_v;
        logic [ADDR_W-1:0] dmd_a;
        logic              rsp_v;
        logic [ADDR_W-1:0] rsp_a;
        logic              pf_v;
        logic [ADDR_W-1:0] pf_a;
    } iss_t;

    iss_t iss_d, iss_q;

    always_comb begin
        iss_d       = iss_q;
        iss_d.dmd_v = miss_valid;
        if (miss_valid) begin
            iss_d.dmd_a = miss_addr;
        end
        // candidate under lookup moves to the response stage unless aborted
        iss_d.rsp_v = probe_valid && !miss_valid;
        iss_d.rsp_a = probe_addr;
        // response stage: issue only on a miss in both tags and buffer
        iss_d.pf_v  = iss_q.rsp_v && !tag_hit && !pend_hit && !miss_valid;
        if (iss_d.pf_v) begin
            iss_d.pf_a = iss_q.rsp_a;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_q <= '0;
        end else begin
            iss_q <= iss_d;
        end
    end

    assign dmd_valid = iss_q.dmd_v;
    assign dmd_addr  = iss_q.dmd_a;
    assign rsp_busy  = iss_q.rsp_v;
    assign pf_valid  = iss_q.pf_v;
    assign pf_addr   = iss_q.pf_a;

    assert_hit_filtered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_busy && (tag_hit || pend_hit)) |=> !pf_valid);

    assert_demand_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> (dmd_valid && !pf_valid));

    assert_abort_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> (!pf_valid ##1 !pf_valid));
endmodule

// File: rtl/spf_reply_trk.sv
module spf_reply_trk
    import spf_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int MAX_INFL = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pf_valid,
    input  logic                          rpl_valid,
    input  logic                          rpl_is_data,
    input  logic [ADDR_W-1:0]             rpl_addr,
    output logic                          install_valid,
    output logic [ADDR_W-1:0]             install_addr,
    output logic [$clog2(MAX_INFL+1)-1:0] pf_inflight
);
    localparam int CNT_W = $clog2(MAX_INFL + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_INFL);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              inst_v;
        logic [ADDR_W-1:0] inst_a;
    } trk_t;

    trk_t trk_d, trk_q;
    logic take;
    rpl_kind_e kind;

    always_comb begin
        trk_d  = trk_q;
        kind   = rpl_kind_e'(rpl_is_data);
        take   = rpl_valid && (trk_q.cnt != '0);
        unique case ({pf_valid, take})
            2'b10:   trk_d.cnt = (trk_q.cnt == CNT_MAX) ? trk_q.cnt : trk_q.cnt + CNT_ONE;
            2'b01:   trk_d.cnt = trk_q.cnt - CNT_ONE;
            default: trk_d.cnt = trk_q.cnt;
        endcase
        trk_d.inst_v = take && (kind == RPL_DATA);
        if (trk_d.inst_v) begin
            trk_d.inst_a = rpl_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign install_valid = trk_q.inst_v;
    assign install_addr  = trk_q.inst_a;
    assign pf_inflight   = trk_q.cnt;

    assert_count_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pf_inflight <= CNT_MAX);

    assert_install_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rpl_valid && rpl_is_data && pf_inflight != '0)
        |=> (install_valid && install_addr == $past(rpl_addr)));

    assert_stray_reply_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rpl_valid && pf_inflight == '0 && !pf_valid)
        |=> (!install_valid && pf_inflight == '0));
endmodule

// File: rtl/seq_prefetch_engine.sv
module seq_prefetch_engine #(
    parameter int ADDR_W   = 16,
    parameter int DEGREE   = 4,
    parameter int MAX_INFL = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          miss_valid,
    input  logic [ADDR_W-1:0]             miss_addr,
    output logic                          dmd_valid,
    output logic [ADDR_W-1:0]             dmd_addr,
    output logic                          lookup_valid,
    output logic [ADDR_W-1:0]             lookup_addr,
    input  logic                          tag_hit,
    input  logic                          pend_hit,
    output logic                          pf_valid,
    output logic [ADDR_W-1:0]             pf_addr,
    input  logic                          rpl_valid,
    input  logic                          rpl_is_data,
    input  logic [ADDR_W-1:0]             rpl_addr,
    output logic                          install_valid,
    output logic [ADDR_W-1:0]             install_addr,
    output logic [$clog2(MAX_INFL+1)-1:0] pf_inflight,
    output logic                          busy
);
    logic rsp_busy;

    spf_walker #(.ADDR_W(ADDR_W), .DEGREE(DEGREE)) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_valid  (miss_valid),
        .miss_addr   (miss_addr),
        .probe_valid (lookup_valid),
        .probe_addr  (lookup_addr)
    );

    spf_issue #(.ADDR_W(ADDR_W)) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_valid  (miss_valid),
        .miss_addr   (miss_addr),
        .probe_valid (lookup_valid),
        .probe_addr  (lookup_addr),
        .tag_hit     (tag_hit),
        .pend_hit    (pend_hit),
        .dmd_valid   (dmd_valid),
        .dmd_addr    (dmd_addr),
        .rsp_busy    (rsp_busy),
        .pf_valid    (pf_valid),
        .pf_addr     (pf_addr)
    );

    spf_reply_trk #(.ADDR_W(ADDR_W), .MAX_INFL(MAX_INFL)) u_trk (
        .clk           (clk),
        .rst_n         (rst_n),
        .pf_valid      (pf_valid),
        .rpl_valid     (rpl_valid),
        .rpl_is_data   (rpl_is_data),
        .rpl_addr      (rpl_addr),
        .install_valid (install_valid),
        .install_addr  (install_addr),
        .pf_inflight   (pf_inflight)
    );

    assign busy = lookup_valid | rsp_busy;

    assert_busy_after_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && DEGREE > 0) |=> busy);
endmodule

// File: tb/seq_prefetch_engine_tb.sv
module seq_prefetch_engine_tb;
    localparam int AW   = 16;
    localparam int K    = 4;
    localparam int MAXI = 8;
    localparam int CW   = $clog2(MAXI + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic          rpl_valid = 1'b0;
    logic          rpl_is_data = 1'b0;
    logic [AW-1:0] rpl_addr = '0;
    logic          dmd_valid, lookup_valid, pf_valid, install_valid, busy;
    logic [AW-1:0] dmd_addr, lookup_addr, pf_addr, install_addr;
    logic [CW-1:0] pf_inflight;
    logic          tag_hit, pend_hit;

    logic          dmd_valid_k0, lookup_valid_k0, pf_valid_k0, install_valid_k0, busy_k0;
    logic [AW-1:0] dmd_addr_k0, lookup_addr_k0, pf_addr_k0, install_addr_k0;
    logic [CW-1:0] pf_inflight_k0;

    logic [63:0]   cmask = '0;
    logic [63:0]   pmask = '0;
    logic          rb_v;
    logic [AW-1:0] rb_a;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_v <= 1'b0;
            rb_a <= '0;
        end else begin
            rb_v <= lookup_valid;
            rb_a <= lookup_addr;
        end
    end
    assign tag_hit  = rb_v && cmask[rb_a[5:0]];
    assign pend_hit = rb_v && pmask[rb_a[5:0]];

    seq_prefetch_engine #(.ADDR_W(AW), .DEGREE(K), .MAX_INFL(MAXI)) u_dut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .dmd_valid(dmd_valid), .dmd_addr(dmd_addr),
        .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
        .tag_hit(tag_hit), .pend_hit(pend_hit),
        .pf_valid(pf_valid), .pf_addr(pf_addr),
        .rpl_valid(rpl_valid), .rpl_is_data(rpl_is_data), .rpl_addr(rpl_addr),
        .install_valid(install_valid), .install_addr(install_addr),
        .pf_inflight(pf_inflight), .busy(busy)
    );

    seq_prefetch_engine #(.ADDR_W(AW), .DEGREE(0), .MAX_INFL(MAXI)) u_dut_k0 (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .dmd_valid(dmd_valid_k0), .dmd_addr(dmd_addr_k0),
        .lookup_valid(lookup_valid_k0), .lookup_addr(lookup_addr_k0),
        .tag_hit(1'b0), .pend_hit(1'b0),
        .pf_valid(pf_valid_k0), .pf_addr(pf_addr_k0),
        .rpl_valid(1'b0), .rpl_is_data(1'b0), .rpl_addr('0),
        .install_valid(install_valid_k0), .install_addr(install_addr_k0),
        .pf_inflight(pf_inflight_k0), .busy(busy_k0)
    );

    int n_chk = 0;
    int n_fail = 0;
    int exp_infl = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // caller stands at a falling edge; returns at the falling edge of cycle 1
    task automatic launch(input logic [AW-1:0] a);
        miss_valid = 1'b1;
        miss_addr  = a;
        @(posedge clk);
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    // checks cycles 1..K+2 after the miss edge, then the count one cycle later
    task automatic observe(input logic [AW-1:0] a, input string areq);
        int issued = 0;
        for (int i = 1; i <= K + 2; i++) begin
            logic [AW-1:0] c;
            bit elig;
            if (i == 1) begin
                chk("R1", "dmd_valid", dmd_valid, 1);
                chk("R1", "dmd_addr", dmd_addr, a);
                chk("R8", "k0 dmd_valid", dmd_valid_k0, 1);
                chk("R8", "k0 dmd_addr", dmd_addr_k0, a);
            end else begin
                chk("R1", "dmd_valid one cycle", dmd_valid, 0);
            end
            if (i <= K) begin
                chk("R2", "lookup_valid", lookup_valid, 1);
                chk(areq, "lookup_addr", lookup_addr, AW'(a + AW'(i)));
            end else begin
                chk("R2", "lookup idle", lookup_valid, 0);
            end
            chk("R7", "busy", busy, (i <= K + 1) ? 1 : 0);
            chk("R8", "k0 quiet", {lookup_valid_k0, busy_k0, pf_valid_k0}, 0);
            if (i >= 3) begin
                c    = AW'(a + AW'(i - 2));
                elig = !cmask[c[5:0]] && !pmask[c[5:0]];
                chk("R4", "pf_valid", pf_valid, elig);
                if (elig) begin
                    chk("R4", "pf_addr", pf_addr, c);
                    issued++;
                end
            end else begin
                chk("R5", "no pf right after miss", pf_valid, 0);
            end
            @(negedge clk);
        end
        exp_infl = (exp_infl + issued > MAXI) ? MAXI : exp_infl + issued;
        chk("R9", "pf_inflight", pf_inflight, exp_infl);
    endtask

    task automatic reply(input bit is_data, input logic [AW-1:0] a, input string req);
        bit acc = (exp_infl > 0);
        rpl_valid   = 1'b1;
        rpl_is_data = is_data;
        rpl_addr    = a;
        @(posedge clk);
        @(negedge clk);
        rpl_valid = 1'b0;
        if (acc) exp_infl--;
        chk(req, "install_valid", install_valid, (acc && is_data) ? 1 : 0);
        if (acc && is_data) chk(req, "install_addr", install_addr, a);
        chk(req, "pf_inflight after reply", pf_inflight, exp_infl);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R7", "reset busy", busy, 0);
        chk("R1", "reset dmd_valid", dmd_valid, 0);
        chk("R4", "reset pf_valid", pf_valid, 0);
        chk("R9", "reset pf_inflight", pf_inflight, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_filter();
        cmask = 64'd1 << 6'h12;
        pmask = 64'd1 << 6'h14;
        launch(16'h0010);
        observe(16'h0010, "R2");
    endtask

    task automatic t_all_filtered();
        cmask = (64'd1 << 6'h21) | (64'd1 << 6'h22) | (64'd1 << 6'h24);
        pmask = (64'd1 << 6'h23) | (64'd1 << 6'h22);
        launch(16'h0020);
        observe(16'h0020, "R2");
    endtask

    task automatic t_wrap();
        cmask = '0;
        pmask = '0;
        launch(16'hFFFE);
        observe(16'hFFFE, "R3");
    endtask

    task automatic t_replies();
        reply(1'b1, 16'hFFFF, "R10");
        reply(1'b0, 16'h0000, "R10");
        reply(1'b1, 16'h0011, "R10");
        reply(1'b0, 16'h0013, "R10");
        reply(1'b1, 16'h0001, "R10");
        reply(1'b1, 16'h0002, "R10");
        chk("R11", "count drained", pf_inflight, 0);
        reply(1'b1, 16'h0777, "R11");
        reply(1'b0, 16'h0778, "R11");
    endtask

    task automatic t_abort();
        cmask = '0;
        pmask = '0;
        launch(16'h0100);
        chk("R6", "old walk first probe", lookup_addr, 16'h0101);
        launch(16'h0200);
        chk("R6", "old response dropped", pf_valid, 0);
        chk("R6", "restart probe", lookup_addr, 16'h0201);
        observe(16'h0200, "R6");
    endtask

    task automatic t_saturate();
        cmask = '0;
        pmask = '0;
        launch(16'h0300);
        observe(16'h0300, "R9");
        launch(16'h0400);
        observe(16'h0400, "R9");
        chk("R9", "saturated at max", pf_inflight, MAXI);
    endtask

    initial begin
        t_reset();
        t_filter();
        t_all_filtered();
        t_wrap();
        t_replies();
        t_abort();
        t_saturate();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule